// File: doc/BRIEF.md
# Next-Instruction Address Unit

This block owns the program counter of a single-cycle core and decides, every clock, which instruction word to fetch next. It receives the instruction currently executing, the zero flag from the ALU and the value read from the first source register. From these it produces the byte program counter, the sequential successor, the word address for a synchronous instruction memory and the return address that a call writes back.

Five kinds of control transfer are recognised: branch-if-equal, branch-if-not-equal, absolute jump, jump-and-link and jump-through-register. Every other instruction falls through to the next word. The instruction memory is indexed by word, so the program counter keeps its two low bits at zero. Its width follows from the number of word-address bits, which is a parameter (8 by default, for 256 words). The word address goes out combinationally, one cycle ahead of the program counter register. This lets a memory that registers its address deliver the matching instruction just after the edge that loads the counter.

Top module: `nextpc_unit`

## Requirements
- R1: While `rst` is high at a rising clock edge the program counter becomes 0, and while `rst` is high `fetch_word` is 0 and `link_we` is 0.
- R2: `pc_plus4` always equals `pc` + 4 modulo 2^(WORD_AW+2). An instruction that is not a control transfer (any opcode other than 0, 2, 3, 4, 5) loads `pc_plus4` into the program counter.
- R3: Bits 1:0 of `pc`, `pc_plus4` and `link_value` are always 0, including after a register jump to an unaligned address.
- R4: Opcode 4 in instruction bits 31:26 (branch-if-equal) is taken when `zero_flag` is 1. When `zero_flag` is 0 the next address is sequential.
- R5: Opcode 5 (branch-if-not-equal) is taken when `zero_flag` is 0. When `zero_flag` is 1 the next address is sequential.
- R6: A taken branch's word target is the word address of `pc_plus4` plus the sign-extended offset in bits 15:0, modulo 2^WORD_AW, so it wraps in both directions.
- R7: Opcode 2 (jump) loads the low WORD_AW bits of the 26-bit field in bits 25:0 as the word address, whatever the state of `zero_flag`.
- R8: Opcode 3 (jump-and-link) jumps exactly like opcode 2. In the same cycle it raises `link_we` and presents `pc_plus4`, zero-extended to 32 bits, on `link_value`. `link_we` is 0 for every other opcode.
- R9: Opcode 0 with function code 8 in bits 5:0 loads bits WORD_AW+1:2 of `rs_value` as the word address. Opcode 0 with any other function code is sequential.
- R10: `fetch_word` equals the word address (bits WORD_AW+1:2) that `pc` takes after the next rising edge.
- R11: Reset takes priority over every control transfer presented in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| instr | input | 32 | Instruction at the current program counter |
| zero_flag | input | 1 | ALU result-is-zero flag for the current instruction |
| rs_value | input | 32 | First source register value, used by jump-through-register |
| pc | output | WORD_AW+2 | Byte program counter, low two bits zero |
| pc_plus4 | output | WORD_AW+2 | Sequential successor of `pc` |
| fetch_word | output | WORD_AW | Word address of the next instruction to fetch |
| link_value | output | 32 | Return address for jump-and-link |
| link_we | output | 1 | Request to write `link_value` into the return-address register |

## Verification
The bench builds the unit with WORD_AW = 5, a 32-word space. At that size branch offsets wrap past both ends of memory within a few steps. The 26-bit jump field and the register value also carry many bits above the implemented width, so truncation in R6, R7 and R9 is exercised on almost every transfer. A behavioural model tracks the word address as an integer and is compared on every cycle, through directed corner cases and then a long mixed stream with occasional resets that land on jumps.

// File: rtl/npc_pkg.sv
package npc_pkg;

    localparam int INSTR_W = 32;
    localparam int DATA_W  = 32;
    localparam int OFFS_W  = 16;
    localparam int TGT_W   = 26;

    localparam logic [5:0] OPC_SPECIAL = 6'd0;
    localparam logic [5:0] OPC_JUMP    = 6'd2;
    localparam logic [5:0] OPC_CALL    = 6'd3;
    localparam logic [5:0] OPC_BR_EQ   = 6'd4;
    localparam logic [5:0] OPC_BR_NE   = 6'd5;
    localparam logic [5:0] FN_REG_JUMP = 6'd8;

    typedef enum logic [1:0] {
        SRC_SEQ    = 2'd0,
        SRC_BRANCH = 2'd1,
        SRC_ABS    = 2'd2,
        SRC_REG    = 2'd3
    } npc_src_e;

    typedef struct packed {
        logic              br_eq;
        logic              br_ne;
        logic              abs_jump;
        logic              call;
        logic              reg_jump;
        logic [OFFS_W-1:0] offset;
        logic [TGT_W-1:0]  target;
    } xfer_ctl_t;

    function automatic logic [5:0] opcode_of(input logic [INSTR_W-1:0] w);
        return w[31:26];
    endfunction

    function automatic logic [5:0] funct_of(input logic [INSTR_W-1:0] w);
        return w[5:0];
    endfunction

    function automatic logic [DATA_W-1:0] sext_offset(input logic [OFFS_W-1:0] v);
        return {{(DATA_W-OFFS_W){v[OFFS_W-1]}}, v};
    endfunction

endpackage

// File: rtl/npc_decode.sv
module npc_decode
    import npc_pkg::*;
(
    input  logic [INSTR_W-1:0] instr,
    output xfer_ctl_t          ctl
);
    logic [5:0] opc;
    logic [5:0] fn;

    always_comb begin
        opc          = opcode_of(instr);
        fn           = funct_of(instr);
        ctl.br_eq    = (opc == OPC_BR_EQ);
        ctl.br_ne    = (opc == OPC_BR_NE);
        ctl.call     = (opc == OPC_CALL);
        ctl.abs_jump = (opc == OPC_JUMP) || (opc == OPC_CALL);
        ctl.reg_jump = (opc == OPC_SPECIAL) && (fn == FN_REG_JUMP);
        ctl.offset   = instr[OFFS_W-1:0];
        ctl.target   = instr[TGT_W-1:0];
    end

    always_comb begin
        a_r8_call_is_jump: assert (!ctl.call || ctl.abs_jump)
            else $error("call not treated as absolute jump");
        a_r9_one_kind: assert ($onehot0({ctl.br_eq, ctl.br_ne, ctl.abs_jump, ctl.reg_jump}))
            else $error("more than one transfer kind decoded");
    end
endmodule

// File: rtl/npc_targets.sv
module npc_targets
    import npc_pkg::*;
#(
    parameter int WORD_AW = 8
) (
    input  logic [WORD_AW-1:0] pc_word,
    input  logic [OFFS_W-1:0]  offset,
    input  logic [TGT_W-1:0]   target,
    input  logic [DATA_W-1:0]  rs_value,
    output logic [WORD_AW-1:0] seq_word,
    output logic [WORD_AW-1:0] branch_word,
    output logic [WORD_AW-1:0] abs_word,
    output logic [WORD_AW-1:0] reg_word
);
    localparam int PC_W = WORD_AW + 2;

    logic [DATA_W-1:0] offs_ext;

    assign seq_word    = pc_word + WORD_AW'(1);
    assign offs_ext    = sext_offset(offset);
    assign branch_word = seq_word + offs_ext[WORD_AW-1:0];
    assign reg_word    = rs_value[PC_W-1:2];

    generate
        if (WORD_AW < TGT_W) begin : g_abs_trunc
            logic unused_tgt_hi;
            assign unused_tgt_hi = ^target[TGT_W-1:WORD_AW];
            assign abs_word      = target[WORD_AW-1:0];
        end else if (WORD_AW == TGT_W) begin : g_abs_exact
            assign abs_word = target;
        end else begin : g_abs_region
            assign abs_word = {seq_word[WORD_AW-1:TGT_W], target};
        end

        if (PC_W < DATA_W) begin : g_rs_trunc
            logic unused_rs;
            assign unused_rs = ^{rs_value[DATA_W-1:PC_W], rs_value[1:0]};
        end else begin : g_rs_full
            logic unused_rs;
            assign unused_rs = ^rs_value[1:0];
        end

        if (WORD_AW < DATA_W) begin : g_offs_trunc
            logic unused_offs;
            assign unused_offs = ^offs_ext[DATA_W-1:WORD_AW];
        end
    endgenerate
endmodule

// File: rtl/npc_select.sv
module npc_select
    import npc_pkg::*;
#(
    parameter int WORD_AW = 8
) (
    input  logic               clk,
    input  logic               rst,
    input  xfer_ctl_t          ctl,
    input  logic               zero_flag,
    input  logic [WORD_AW-1:0] seq_word,
    input  logic [WORD_AW-1:0] branch_word,
    input  logic [WORD_AW-1:0] abs_word,
    input  logic [WORD_AW-1:0] reg_word,
    output npc_src_e           src,
    output logic [WORD_AW-1:0] next_word
);
    logic br_taken;

    assign br_taken = (ctl.br_eq && zero_flag) || (ctl.br_ne && !zero_flag);

    always_comb begin
        if (ctl.reg_jump)      src = SRC_REG;
        else if (ctl.abs_jump) src = SRC_ABS;
        else if (br_taken)     src = SRC_BRANCH;
        else                   src = SRC_SEQ;
    end

    always_comb begin
        if (rst) begin
            next_word = '0;
        end else begin
            unique case (src)
                SRC_REG:    next_word = reg_word;
                SRC_ABS:    next_word = abs_word;
                SRC_BRANCH: next_word = branch_word;
                default:    next_word = seq_word;
            endcase
        end
    end

    a_r4_eq_not_taken: assert property (@(posedge clk) disable iff (rst)
        (ctl.br_eq && !zero_flag) |-> (next_word == seq_word))
        else $error("branch-if-equal taken with zero flag clear");

    a_r5_ne_taken: assert property (@(posedge clk) disable iff (rst)
        (ctl.br_ne && !zero_flag) |-> (next_word == branch_word))
        else $error("branch-if-not-equal not taken with zero flag clear");

    a_r9_reg_target: assert property (@(posedge clk) disable iff (rst)
        ctl.reg_jump |-> (next_word == reg_word))
        else $error("register jump did not follow source register");

    a_r11_reset_first: assert property (@(posedge clk)
        rst |-> (next_word == '0))
        else $error("reset did not override next address");
endmodule

// File: rtl/npc_pc_reg.sv
module npc_pc_reg #(
    parameter int WORD_AW = 8
) (
    input  logic               clk,
    input  logic               rst,
    input  logic [WORD_AW-1:0] next_word,
    output logic [WORD_AW-1:0] pc_word
);
    always_ff @(posedge clk) begin
        if (rst) pc_word <= '0;
        else     pc_word <= next_word;
    end

    a_r1_reset_clears: assert property (@(posedge clk)
        rst |=> (pc_word == '0))
        else $error("program counter not cleared by reset");
endmodule

// File: rtl/nextpc_unit.sv
module nextpc_unit
    import npc_pkg::*;
#(
    parameter int WORD_AW = 8,
    localparam int PC_W   = WORD_AW + 2
) (
    input  logic               clk,
    input  logic               rst,
    input  logic [31:0]        instr,
    input  logic               zero_flag,
    input  logic [31:0]        rs_value,
    output logic [PC_W-1:0]    pc,
    output logic [PC_W-1:0]    pc_plus4,
    output logic [WORD_AW-1:0] fetch_word,
    output logic [31:0]        link_value,
    output logic               link_we
);
    xfer_ctl_t          ctl;
    npc_src_e           src;
    logic [WORD_AW-1:0] pc_word;
    logic [WORD_AW-1:0] seq_word;
    logic [WORD_AW-1:0] branch_word;
    logic [WORD_AW-1:0] abs_word;
    logic [WORD_AW-1:0] reg_word;
    logic [WORD_AW-1:0] next_word;

    npc_decode u_decode (
        .instr (instr),
        .ctl   (ctl)
    );

    npc_targets #(.WORD_AW(WORD_AW)) u_targets (
        .pc_word     (pc_word),
        .offset      (ctl.offset),
        .target      (ctl.target),
        .rs_value    (rs_value),
        .seq_word    (seq_word),
        .branch_word (branch_word),
        .abs_word    (abs_word),
        .reg_word    (reg_word)
    );

    npc_select #(.WORD_AW(WORD_AW)) u_select (
        .clk         (clk),
        .rst         (rst),
        .ctl         (ctl),
        .zero_flag   (zero_flag),
        .seq_word    (seq_word),
        .branch_word (branch_word),
        .abs_word    (abs_word),
        .reg_word    (reg_word),
        .src         (src),
        .next_word   (next_word)
    );

    npc_pc_reg #(.WORD_AW(WORD_AW)) u_pc (
        .clk       (clk),
        .rst       (rst),
        .next_word (next_word),
        .pc_word   (pc_word)
    );

    assign pc         = {pc_word, 2'b00};
    assign pc_plus4   = {seq_word, 2'b00};
    assign fetch_word = next_word;
    assign link_value = 32'(pc_plus4);
    assign link_we    = ctl.call && !rst;

    a_r3_pc_aligned: assert property (@(posedge clk) disable iff (rst)
        (pc[1:0] == 2'b00) && (link_value[1:0] == 2'b00))
        else $error("unaligned program counter");

    a_r2_sequential_step: assert property (@(posedge clk) disable iff (rst)
        (src == SRC_SEQ) |=> (pc == $past(pc) + PC_W'(4)))
        else $error("sequential step not by four bytes");

    a_r10_fetch_matches_pc: assert property (@(posedge clk) disable iff (rst)
        1'b1 |=> (pc[PC_W-1:2] == $past(fetch_word)))
        else $error("fetched word differs from loaded counter");

    a_r8_link_only_call: assert property (@(posedge clk) disable iff (rst)
        link_we |-> (src == SRC_ABS))
        else $error("link write without absolute jump");
endmodule

// File: tb/test_nextpc_unit.sv
module test_nextpc_unit;
    localparam int AW   = 5;
    localparam int PW   = AW + 2;
    localparam int MASK = (1 << AW) - 1;

    logic          clk = 1'b0;
    logic          rst;
    logic [31:0]   instr;
    logic          zero_flag;
    logic [31:0]   rs_value;
    logic [PW-1:0] pc;
    logic [PW-1:0] pc_plus4;
    logic [AW-1:0] fetch_word;
    logic [31:0]   link_value;
    logic          link_we;

    int n_cmp = 0;
    int n_bad = 0;
    int model_word = 0;
    bit done = 0;

    always #10 clk = ~clk;

    nextpc_unit #(.WORD_AW(AW)) i_nextpc_unit (
        .clk        (clk),
        .rst        (rst),
        .instr      (instr),
        .zero_flag  (zero_flag),
        .rs_value   (rs_value),
        .pc         (pc),
        .pc_plus4   (pc_plus4),
        .fetch_word (fetch_word),
        .link_value (link_value),
        .link_we    (link_we)
    );

    function automatic logic [31:0] mk_i(input int op, input logic [25:0] body);
        return {op[5:0], body};
    endfunction

    function automatic logic [31:0] mk_br(input int op, input int offs);
        return {op[5:0], 10'd0, offs[15:0]};
    endfunction

    task automatic check(input string tag, input string what, input longint act, input longint exp);
        n_cmp++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
        end
    endtask

    task automatic step(input logic r, input logic [31:0] ins, input logic z, input logic [31:0] rv);
        int op, fn, seq, nxt, offs;
        string tag;
        @(negedge clk);
        rst = r; instr = ins; zero_flag = z; rs_value = rv;
        #2;
        op   = int'(ins[31:26]);
        fn   = int'(ins[5:0]);
        seq  = (model_word + 1) & MASK;
        offs = int'(ins[15:0]);
        if (offs >= 32768) offs -= 65536;
        if (r)                                 begin nxt = 0;                          tag = "R11"; end
        else if (op == 0 && fn == 8)           begin nxt = int'(rv >> 2) & MASK;       tag = "R9";  end
        else if (op == 2)                      begin nxt = int'(ins[25:0]) & MASK;     tag = "R7";  end
        else if (op == 3)                      begin nxt = int'(ins[25:0]) & MASK;     tag = "R8";  end
        else if (op == 4 && z)                 begin nxt = (seq + offs) & MASK;        tag = "R6";  end
        else if (op == 5 && !z)                begin nxt = (seq + offs) & MASK;        tag = "R6";  end
        else if (op == 4)                      begin nxt = seq;                        tag = "R4";  end
        else if (op == 5)                      begin nxt = seq;                        tag = "R5";  end
        else                                   begin nxt = seq;                        tag = "R2";  end
        check("R1", "pc", pc, model_word << 2);
        check("R2", "pc_plus4", pc_plus4, seq << 2);
        check("R3", "pc low bits", {pc[1:0], pc_plus4[1:0], link_value[1:0]}, 0);
        check({tag, " R10"}, "fetch_word", fetch_word, nxt);
        check("R8", "link_we", link_we, (op == 3 && !r) ? 1 : 0);
        check("R8", "link_value", link_value, seq << 2);
        model_word = nxt;
    endtask

    initial begin
        rst = 1'b1; instr = '0; zero_flag = 1'b0; rs_value = '0;
        @(posedge clk);
        // R1 R11: reset held with a jump and a register jump present
        step(1'b1, mk_i(2, 26'h15), 1'b0, 32'h0);
        step(1'b1, {6'd0, 20'd0, 6'd8}, 1'b0, 32'h7C);
        // R2: plain instructions
        for (int k = 0; k < 3; k++) step(1'b0, mk_i(35, 26'h3), 1'b1, 32'h0);
        // R4: equal branch not taken, then taken forward
        step(1'b0, mk_br(4, 5), 1'b0, 32'h0);
        step(1'b0, mk_br(4, 5), 1'b1, 32'h0);
        // R5: not-equal branch not taken, then taken backward
        step(1'b0, mk_br(5, -3), 1'b1, 32'h0);
        step(1'b0, mk_br(5, -3), 1'b0, 32'h0);
        // R6: wrap below zero and past the top
        step(1'b0, mk_br(4, -20), 1'b1, 32'h0);
        step(1'b0, mk_br(5, 40), 1'b0, 32'h0);
        // R7: jump with high target bits set, zero flag irrelevant
        step(1'b0, mk_i(2, 26'h3FFFFE9), 1'b1, 32'h0);
        // R8: call
        step(1'b0, mk_i(3, 26'h0000004), 1'b0, 32'h0);
        // R9: register jump to unaligned address, then wrong function code
        step(1'b0, {6'd0, 20'd0, 6'd8}, 1'b0, 32'hFFFF_FF6F);
        step(1'b0, {6'd0, 20'd0, 6'd9}, 1'b0, 32'h0000_0040);
        // R2: top of memory wraps to word 0
        step(1'b0, mk_i(2, 26'h1F), 1'b0, 32'h0);
        step(1'b0, mk_i(8, 26'h0), 1'b0, 32'h0);
        // R11: reset arriving mid-run over a call
        step(1'b1, mk_i(3, 26'h9), 1'b0, 32'h0);
        // mixed stream
        for (int k = 0; k < 3000; k++) begin
            int pick, op;
            logic [31:0] ins;
            pick = $urandom_range(0, 7);
            case (pick)
                0: op = 0; 1: op = 2; 2: op = 3; 3: op = 4; 4: op = 5;
                5: op = 4; 6: op = 5; default: op = $urandom_range(6, 63);
            endcase
            ins = {op[5:0], 26'($urandom)};
            if (op == 0 && $urandom_range(0, 1) == 1) ins[5:0] = 6'd8;
            step(($urandom_range(0, 99) == 0), ins, 1'($urandom), $urandom);
        end
        done = 1;
    end

    initial begin
        fork
            wait (done);
            begin
                repeat (100000) @(posedge clk);
                n_cmp++;
                n_bad++;
                $display("FAIL watchdog: actual timeout expected completion");
            end
        join_any
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule